// File: doc/BRIEF.md
# Warp Work-Item Generator for One-Dimensional Launches

This block turns a single launch request into an ordered stream of warp work items. A request carries a problem size `n` and a block size, in threads. The block works out how many thread blocks the launch needs by rounding `n / size` up. It then walks every block, and every 32-lane warp inside each block. For each warp it emits four values: the warp's first global thread index, the block number, the warp number within the block, and a lane mask. A lane is enabled only when its global thread index is below `n`. Every warp of every block is emitted, so a warp whose lanes all lie past `n` still appears, with a zero mask.

Work items leave on a valid/ready stream. An item is transferred in a cycle where `item_valid_o` and `item_ready_i` are both high. While `item_ready_i` is low, the offered item stays unchanged until it is taken. The producer never withdraws an item it has offered. `start_i`, `busy_o`, `done_o` and `err_o` are plain control and status pins.

Global indices must stay representable. `n` may be at most 2^IDX_W − MAX_BLK.

Top module: `gwg_warp_gen`

## Requirements
- R1: After reset, `item_valid_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: A `start_i` pulse whose block size is zero, is not a multiple of 32, or exceeds 512 raises `err_o` for exactly one cycle, in the cycle after the start. The block emits no item and raises no `done_o` for that request.
- R3: A `start_i` pulse with a valid block size and `n` = 0 emits no item. It raises `done_o` for one cycle, in the cycle after the start.
- R4: The launch emits exactly ceil(n / size) × (size / 32) items.
- R5: Items come out in ascending order, by block first and then by warp. Item k has block number k / (size/32) and warp number k mod (size/32). Its base index is block × size + 32 × warp.
- R6: Bit i of the lane mask (bit 0 = lane 0) is 1 exactly when base + i < n.
- R7: While `item_valid_o` is high and `item_ready_i` is low, the next cycle still shows `item_valid_o` high, with the same base and the same mask.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last item is accepted. No item is offered in that cycle.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running launch completes with its original `n` and block size.
- R10: For n = 8192 and size 512, the launch produces 16 blocks. The last item has block 15, warp 15 and base 8160, with all 32 lanes enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Launch request pulse; accepted only while idle |
| n_i | input | IDX_W | Problem size in threads |
| bsize_i | input | BS_W | Threads per block |
| item_valid_o | output | 1 | A work item is offered |
| item_ready_i | input | 1 | Consumer takes the offered item |
| item_base_o | output | IDX_W | Global index of lane 0 of the warp |
| item_mask_o | output | LANES | Lane-enable mask, bit i for lane i |
| item_block_o | output | IDX_W | Block number of the item |
| item_warp_o | output | WARP_W | Warp number inside the block |
| busy_o | output | 1 | A launch is being sized or streamed |
| done_o | output | 1 | One-cycle pulse after the final item is accepted |
| err_o | output | 1 | One-cycle pulse on a start with a bad block size |

## Verification
Each fault in the internal state shows up at the ports within the next handshake:
- A wrong block count from the divider changes the number of items before `done_o`. It also moves the `done_o` pulse, so the item count and the done timing expose it.
- A warp counter that wraps at the wrong point shows as a wrong base, block or warp on the very next accepted item.
- A bad comparison in the mask logic shows on the first warp that straddles `n`.
- Loss of hold under back-pressure shows one cycle after a refused item.

The stall patterns and the straddling sizes are chosen so that every one of these appears on the ports.

// File: rtl/gwg_pkg.sv
package gwg_pkg;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_SIZE = 2'd1,
    GS_EMIT = 2'd2
  } gwg_state_t;

  // Block size check: nonzero, a whole number of warps, not above the limit.
  function automatic logic size_legal(input int unsigned sz,
                                      input int unsigned lanes,
                                      input int unsigned max_blk);
    return (sz != 0) && ((sz % lanes) == 0) && (sz <= max_blk);
  endfunction

endpackage

// File: rtl/gwg_ceil_div.sv
module gwg_ceil_div #(
  parameter int DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   rem_q;
  logic [DW-1:0] quo_q;
  logic [DW-1:0] den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;

  logic [DW:0]   rem_sh;
  logic          fits;
  logic [DW:0]   rem_nx;
  logic [DW-1:0] quo_nx;

  // One restoring step per cycle: shift in the next dividend bit, subtract when it fits.
  always_comb begin
    rem_sh = {rem_q[DW-1:0], quo_q[DW-1]};
    fits   = rem_sh >= {1'b0, den_q};
    rem_nx = fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
    quo_nx = {quo_q[DW-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        den_q  <= den_i;
        cnt_q  <= CW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  // R4: the remainder never reaches the divisor once a step has completed.
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < {1'b0, den_q}));

  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $fell(busy_q));
endmodule

// File: rtl/gwg_lane_mask.sv
module gwg_lane_mask #(
  parameter int IDX_W = 32,
  parameter int LANES = 32
) (
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] n_i,
  output logic [LANES-1:0] mask_o
);
  localparam int XW = IDX_W + 1;

  // Each lane compares its own global index against the problem size.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [XW-1:0] gidx;
    assign gidx      = {1'b0, base_i} + XW'(g);
    assign mask_o[g] = gidx < {1'b0, n_i};
  end
endmodule

// File: rtl/gwg_warp_gen.sv
module gwg_warp_gen
  import gwg_pkg::*;
#(
  parameter int IDX_W   = 32,
  parameter int LANES   = 32,
  parameter int MAX_BLK = 512,
  parameter int BS_W    = $clog2(MAX_BLK) + 1,
  parameter int WARP_W  = ((MAX_BLK / LANES) > 1) ? $clog2(MAX_BLK / LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  n_i,
  input  logic [BS_W-1:0]   bsize_i,
  output logic              item_valid_o,
  input  logic              item_ready_i,
  output logic [IDX_W-1:0]  item_base_o,
  output logic [LANES-1:0]  item_mask_o,
  output logic [IDX_W-1:0]  item_block_o,
  output logic [WARP_W-1:0] item_warp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int DW  = IDX_W + 1;
  localparam int LSH = $clog2(LANES);

  gwg_state_t        state_q;
  logic [IDX_W-1:0]  n_q;
  logic [BS_W-1:0]   size_q;
  logic [WARP_W-1:0] wpb_m1_q;
  logic [IDX_W-1:0]  nblk_q;
  logic [IDX_W-1:0]  blk_q;
  logic [WARP_W-1:0] warp_q;
  logic [IDX_W-1:0]  base_q;
  logic              done_q;
  logic              err_q;

  logic              idle;
  logic              size_ok;
  logic              launch;
  logic [DW-1:0]     div_num;
  logic [DW-1:0]     div_den;
  logic              div_busy;
  logic              div_done;
  logic [DW-1:0]     div_quot;
  logic              take;
  logic              end_of_blk;
  logic              last_item;
  logic [LANES-1:0]  lane_mask;

  assign idle    = (state_q == GS_IDLE);
  assign size_ok = size_legal(int'(bsize_i), LANES, MAX_BLK);
  assign launch  = start_i && idle && size_ok && (n_i != '0);

  // Rounded-up block count: (n + size - 1) / size.
  assign div_num = {1'b0, n_i} + DW'(bsize_i) - DW'(1);
  assign div_den = DW'(bsize_i);

  gwg_ceil_div #(.DW(DW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (launch),
    .num_i  (div_num),
    .den_i  (div_den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  gwg_lane_mask #(.IDX_W(IDX_W), .LANES(LANES)) u_mask (
    .base_i (base_q),
    .n_i    (n_q),
    .mask_o (lane_mask)
  );

  assign take       = (state_q == GS_EMIT) && item_ready_i;
  assign end_of_blk = (warp_q == wpb_m1_q);
  assign last_item  = end_of_blk && (blk_q == nblk_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= GS_IDLE;
      n_q      <= '0;
      size_q   <= '0;
      wpb_m1_q <= '0;
      nblk_q   <= '0;
      blk_q    <= '0;
      warp_q   <= '0;
      base_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        GS_IDLE: begin
          if (start_i) begin
            if (!size_ok) begin
              err_q <= 1'b1;
            end else if (n_i == '0) begin
              done_q <= 1'b1;
            end else begin
              n_q      <= n_i;
              size_q   <= bsize_i;
              wpb_m1_q <= WARP_W'((bsize_i >> LSH) - 1'b1);
              state_q  <= GS_SIZE;
            end
          end
        end
        GS_SIZE: begin
          if (div_done) begin
            nblk_q  <= div_quot[IDX_W-1:0];
            blk_q   <= '0;
            warp_q  <= '0;
            base_q  <= '0;
            state_q <= GS_EMIT;
          end
        end
        GS_EMIT: begin
          if (take) begin
            if (last_item) begin
              state_q <= GS_IDLE;
              done_q  <= 1'b1;
            end else begin
              base_q <= base_q + IDX_W'(LANES);
              if (end_of_blk) begin
                warp_q <= '0;
                blk_q  <= blk_q + 1'b1;
              end else begin
                warp_q <= warp_q + 1'b1;
              end
            end
          end
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

  assign item_valid_o = (state_q == GS_EMIT);
  assign item_base_o  = base_q;
  assign item_mask_o  = lane_mask;
  assign item_block_o = blk_q;
  assign item_warp_o  = warp_q;
  assign busy_o       = !idle;
  assign done_o       = done_q;
  assign err_o        = err_q;

  // R7: an offered item is held until taken.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid_o && !item_ready_i) |=>
      (item_valid_o && $stable(item_base_o) && $stable(item_mask_o)));

  // R5: consecutive accepted items are one warp apart.
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (item_valid_o && item_ready_i && !last_item) |=>
      (item_base_o == $past(item_base_o) + IDX_W'(LANES)));

  // R6: enabled lanes form a contiguous run from lane 0.
  a_r6_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid_o |-> ((item_mask_o & (item_mask_o + 1'b1)) == '0));

  // R8: done is a single pulse with no item alongside.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!item_valid_o ##1 !done_o));

  // R2: an error never coincides with an item or with done.
  a_r2_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!item_valid_o && !done_o));

  // R4: the block count covers n and no whole block lies beyond it.
  a_r4_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == GS_SIZE && div_done) |->
      ((64'(div_quot) * 64'(size_q) >= 64'(n_q)) &&
       ((64'(div_quot) - 64'd1) * 64'(size_q) < 64'(n_q))));

  // R9: the divider is busy only while sizing a launch.
  a_r9_div_sizing: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state_q == GS_SIZE));
endmodule

// File: tb/gwg_warp_gen_tb.sv
module gwg_warp_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] n_in = '0;
  logic [9:0]  bs_in = '0;
  logic        ready = 1'b0;
  logic        valid;
  logic [31:0] base;
  logic [31:0] mask;
  logic [31:0] blk;
  logic [3:0]  warp;
  logic        busy;
  logic        done;
  logic        err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int run_got = 0;
  logic [31:0] last_base, last_mask, last_blk;
  logic [3:0]  last_warp;

  always #(CLK_PERIOD/2) clk = ~clk;

  gwg_warp_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .n_i(n_in), .bsize_i(bs_in),
    .item_valid_o(valid), .item_ready_i(ready), .item_base_o(base),
    .item_mask_o(mask), .item_block_o(blk), .item_warp_o(warp),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] exp_mask(input longint b, input longint n);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = (b + i) < n;
    return m;
  endfunction

  task automatic t_reset();
    chk(!valid && !busy && !done && !err, "R1", "idle outputs after reset",
        {valid, busy, done, err}, 0);
  endtask

  task automatic t_bad_size(input int sz);
    @(negedge clk); start = 1; n_in = 100; bs_in = 10'(sz);
    @(negedge clk); start = 0;
    chk(err == 1, "R2", $sformatf("err pulse size %0d", sz), err, 1);
    chk(!valid && !done && !busy, "R2", "no item or done on bad size",
        {valid, done, busy}, 0);
    @(negedge clk);
    chk(err == 0 && !valid && !done, "R2", "err single cycle, still silent",
        {err, valid, done}, 0);
  endtask

  task automatic t_zero_n();
    @(negedge clk); start = 1; n_in = 0; bs_in = 64;
    @(negedge clk); start = 0;
    chk(done == 1 && !valid, "R3", "done right after start with n=0",
        {done, valid}, 2);
    @(negedge clk);
    chk(done == 0 && !valid && !busy, "R3", "no items for n=0",
        {done, valid, busy}, 0);
  endtask

  task automatic run_launch(input int n, input int sz, input int stall,
                            input bit inject, input string tag);
    int  wpb   = sz / 32;
    int  nblk  = (n + sz - 1) / sz;
    int  total = nblk * wpb;
    int  got   = 0;
    int  last_acc = -10;
    bit  seen_done = 0;
    bit  hold_pend = 0;
    logic [31:0] hb, hm;
    @(negedge clk); start = 1; n_in = n; bs_in = 10'(sz); ready = 0;
    @(negedge clk); start = 0;
    for (int cyc = 0; cyc < 20000 && !seen_done; cyc++) begin
      if (inject && cyc == 4) begin
        start = 1; n_in = n + 5; bs_in = 64;
      end else begin
        start = 0;
      end
      ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (hold_pend) begin
        chk(valid && base == hb && mask == hm, "R7",
            {tag, " item held under back-pressure"}, {valid, base}, {1'b1, hb});
      end
      hold_pend = 0;
      if (done) begin
        chk(got == total, "R4", {tag, " item count"}, got, total);
        chk(cyc == last_acc + 1, "R8", {tag, " done one cycle after last"},
            cyc, last_acc + 1);
        chk(!valid, "R8", {tag, " no item with done"}, valid, 0);
        seen_done = 1;
      end else if (valid && ready) begin
        if (got >= total) begin
          chk(0, "R4", {tag, " extra item"}, got, total);
        end else begin
          longint eb = longint'(got / wpb) * sz + 32 * (got % wpb);
          chk(base == 32'(eb) && blk == 32'(got / wpb) && warp == 4'(got % wpb),
              "R5", {tag, $sformatf(" order item %0d", got)}, base, eb);
          chk(mask == exp_mask(eb, n), "R6", {tag, $sformatf(" mask item %0d", got)},
              mask, exp_mask(eb, n));
        end
        last_base = base; last_mask = mask; last_blk = blk; last_warp = warp;
        if (got == total - 1) last_acc = cyc;
        got++;
      end else if (valid) begin
        hold_pend = 1; hb = base; hm = mask;
      end
      @(negedge clk);
    end
    start = 0;
    chk(seen_done, "R8", {tag, " done reached"}, seen_done, 1);
    chk(!done && !valid && !busy, "R8", {tag, " done single pulse, idle"},
        {done, valid, busy}, 0);
    run_got = got;
  endtask

  task automatic t_big();
    run_launch(8192, 512, 0, 0, "n8192");
    chk(last_blk == 15 && last_warp == 15, "R10", "last block/warp",
        {last_blk, 28'(last_warp)}, {32'd15, 28'd15});
    chk(last_base == 8160, "R10", "last base", last_base, 8160);
    chk(last_mask == 32'hFFFF_FFFF, "R10", "last mask full", last_mask, 32'hFFFF_FFFF);
  endtask

  task automatic t_inject();
    run_launch(70, 32, 0, 1, "inject");
    chk(run_got == 3, "R9", "start while busy ignored", run_got, 3);
  endtask

  initial begin
    #1;
    @(negedge clk);
    t_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bad_size(48);
    t_bad_size(0);
    t_bad_size(544);
    t_zero_n();
    run_launch(100, 64, 0, 0, "n100s64");
    run_launch(40, 128, 3, 0, "n40s128");
    run_launch(1000, 96, 2, 0, "n1000s96");
    run_launch(33, 32, 4, 0, "n33s32");
    run_launch(512, 512, 0, 0, "n512s512");
    t_inject();
    t_big();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule